// File: doc/BRIEF.md
# Interrupt Priority Level Controller

This block decides which interrupt request a processor should take next by comparing all pending requests against a current priority level in a 32-level space (0 to 31). The upper sixteen levels come straight from hardware request lines. The lower fifteen levels, 1 to 15, are software requests that are posted by a write and held until they are taken. Level 0 means ordinary code with no handler running. A request is offered only when its level is strictly above the current level. When several are offered, the highest level wins.

Taking a request happens through an acknowledge input. It saves the interrupted level, together with the level the new handler starts at, on an internal frame stack. In the same edge it moves the current level up to the accepted level. A return strobe restores the saved level. Running code may also set, raise or lower its level directly. While a handler is active, any attempt to go below that handler's starting level is clamped to that level and flagged. A typical use is a handler running at a high hardware level that posts a low software request, so that deferred work runs once the level drops below it.

Top module: `ipl_arbiter`

## Requirements
- R1: For the cycles after a synchronous reset, `cur_level` is 31, `nest_depth` is 0, no software request is pending, and `lower_err` and `pop_underflow` are 0.
- R2: Hardware line `hw_req[i]` requests level 16+i. It is level-sensitive and not latched: dropping the line without an acknowledge withdraws the request.
- R3: Bit i of `sw_post` sets a pending software request at level i+1 on the next edge. The request stays pending until an acknowledge accepts that level, which clears it.
- R4: `irq_valid` is 1 exactly when the highest requested level is strictly greater than `cur_level`. `irq_level` then gives that highest level.
- R5: An edge with `irq_ack` and `irq_valid` both high pushes a frame and sets `cur_level` to the accepted `irq_level`. It also raises `nest_depth` by one.
- R6: An `rti` strobe with a non-empty stack pops one frame, restores `cur_level` to the level saved at entry and lowers `nest_depth` by one.
- R7: An `rti` strobe on an empty stack leaves level and depth unchanged. It raises `pop_underflow` for one cycle.
- R8: `lvl_cmd` codes are 0 none, 1 set to `lvl_value`, 2 raise (maximum of current level and `lvl_value`), 3 lower (minimum of current level and `lvl_value`).
- R9: With a handler active, a set or lower below the innermost handler's entry level is clamped to that entry level and pulses `lower_err` for one cycle. With no handler active, the floor is 0 and no command errs.
- R10: In one edge, an accepted acknowledge takes precedence over `rti`, and `rti` takes precedence over `lvl_cmd`. The losing inputs have no effect that edge.
- R11: When a post and an accept hit the same software level in one edge, the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 16 | Hardware request lines, bit i is level 16+i |
| sw_post | input | 15 | Software request post, bit i is level i+1 |
| irq_ack | input | 1 | Accept the offered request |
| rti | input | 1 | Return from handler strobe |
| lvl_cmd | input | 2 | Level command: 0 none, 1 set, 2 raise, 3 lower |
| lvl_value | input | 5 | Operand of the level command |
| irq_valid | output | 1 | A request above the current level is offered |
| irq_level | output | 5 | Level of the offered request |
| cur_level | output | 5 | Current priority level |
| nest_depth | output | 6 | Number of frames on the stack |
| lower_err | output | 1 | One-cycle pulse: a level command was clamped |
| pop_underflow | output | 1 | One-cycle pulse: return strobe with empty stack |

## Verification
Two situations are hardest to reach from the ports. The first is a clamped lowering inside a nested handler. The second is an acknowledge arriving in the same edge as a return strobe or a level command. Both need the level first brought down from its reset value, then a request accepted, and only then the colliding input. A directed sequence builds this up step by step: it lowers the level, accepts a hardware request and then tries to lower below entry. It also fires acknowledge, return and set together, and posts a software level in the same edge that level is accepted. A long run with biased random inputs then mixes nesting, posts and commands, while a behavioural model with a queue for the stack is compared against the design every cycle.

// File: rtl/ipl_pkg.sv
package ipl_pkg;

    localparam int NUM_LEVELS = 32;
    localparam int LVL_W      = $clog2(NUM_LEVELS);
    localparam int HW_BASE    = 16;
    localparam int HW_N       = NUM_LEVELS - HW_BASE;
    localparam int SW_N       = HW_BASE - 1;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        LCMD_NONE  = 2'd0,
        LCMD_SET   = 2'd1,
        LCMD_RAISE = 2'd2,
        LCMD_LOWER = 2'd3
    } lcmd_e;

    // one nesting frame: the level to return to and the level the handler began at
    typedef struct packed {
        lvl_t prev;
        lvl_t entry;
    } frame_t;

    // raw target of a level command before the floor is applied
    function automatic lvl_t cmd_target(lcmd_e cmd, lvl_t cur, lvl_t val);
        lvl_t t;
        unique case (cmd)
            LCMD_SET:   t = val;
            LCMD_RAISE: t = (val > cur) ? val : cur;
            LCMD_LOWER: t = (val < cur) ? val : cur;
            default:    t = cur;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/ipl_sw_pending.sv
module ipl_sw_pending #(
    parameter int N   = 15,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     post,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N-1:0]     pend
);
    logic [N-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        for (int i = 0; i < N; i++) begin
            if (clr_en && (clr_idx == IDX_W'(i))) clr_mask[i] = 1'b1;
        end
    end

    // post is applied after the clear so a same-edge post keeps the request
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_mask) | post;
    end
endmodule

// File: rtl/ipl_pick.sv
module ipl_pick
    import ipl_pkg::*;
(
    input  logic [NUM_LEVELS-1:0] req,
    input  lvl_t                  cur,
    output logic                  valid,
    output lvl_t                  level
);
    logic any;

    always_comb begin
        any   = 1'b0;
        level = '0;
        for (int i = 1; i < NUM_LEVELS; i++) begin
            if (req[i]) begin
                any   = 1'b1;
                level = LVL_W'(i);
            end
        end
        valid = any && (level > cur);
    end
endmodule

// File: rtl/ipl_frame_stack.sv
module ipl_frame_stack
    import ipl_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int DEPTH_W = $clog2(DEPTH + 1),
    parameter int ADDR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic               pop,
    input  frame_t             push_frame,
    output frame_t             top_frame,
    output logic               empty,
    output logic [DEPTH_W-1:0] count
);
    frame_t mem [DEPTH];
    logic   full;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    assign full    = (count == DEPTH_W'(DEPTH));
    assign empty   = (count == '0);
    assign wr_addr = ADDR_W'(count);
    assign rd_addr = ADDR_W'(count - DEPTH_W'(1));
    assign top_frame = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + DEPTH_W'(1);
        end else if (pop && !empty) begin
            count <= count - DEPTH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_addr] <= push_frame;
    end
endmodule

// File: rtl/ipl_arbiter.sv
module ipl_arbiter
    import ipl_pkg::*;
#(
    parameter int STACK_DEPTH = 32,
    localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1),
    localparam int SW_IDX_W   = $clog2(SW_N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HW_N-1:0]    hw_req,
    input  logic [SW_N-1:0]    sw_post,
    input  logic               irq_ack,
    input  logic               rti,
    input  logic [1:0]         lvl_cmd,
    input  logic [LVL_W-1:0]   lvl_value,
    output logic               irq_valid,
    output logic [LVL_W-1:0]   irq_level,
    output logic [LVL_W-1:0]   cur_level,
    output logic [DEPTH_W-1:0] nest_depth,
    output logic               lower_err,
    output logic               pop_underflow
);
    logic [SW_N-1:0]       sw_pend;
    logic [NUM_LEVELS-1:0] req_vec;
    logic                  pick_valid;
    lvl_t                  pick_level;
    frame_t                top_frame;
    frame_t                push_frame;
    logic                  stk_empty;
    logic                  do_push;
    logic                  do_pop;
    logic                  accept;
    logic                  sw_clr;
    lvl_t                  floor_lvl;
    lvl_t                  nxt_level;
    lvl_t                  target;
    logic                  nxt_lerr;
    logic                  nxt_uflow;
    lcmd_e                 cmd;

    assign cmd = lcmd_e'(lvl_cmd);

    // level map: 0 never requested, 1..HW_BASE-1 software, HW_BASE.. hardware
    assign req_vec[0] = 1'b0;
    for (genvar g = 1; g < NUM_LEVELS; g++) begin : g_map
        if (g < HW_BASE) begin : g_sw
            assign req_vec[g] = sw_pend[g-1];
        end else begin : g_hw
            assign req_vec[g] = hw_req[g-HW_BASE];
        end
    end

    ipl_pick u_pick (
        .req   (req_vec),
        .cur   (cur_level),
        .valid (pick_valid),
        .level (pick_level)
    );

    assign accept = irq_ack && pick_valid;
    assign sw_clr = accept && (pick_level < lvl_t'(HW_BASE));

    ipl_sw_pending #(.N(SW_N), .IDX_W(SW_IDX_W)) u_swp (
        .clk     (clk),
        .rst     (rst),
        .post    (sw_post),
        .clr_en  (sw_clr),
        .clr_idx (SW_IDX_W'(pick_level - lvl_t'(1))),
        .pend    (sw_pend)
    );

    assign push_frame.prev  = cur_level;
    assign push_frame.entry = pick_level;

    ipl_frame_stack #(.DEPTH(STACK_DEPTH), .DEPTH_W(DEPTH_W)) u_stk (
        .clk        (clk),
        .rst        (rst),
        .push       (do_push),
        .pop        (do_pop),
        .push_frame (push_frame),
        .top_frame  (top_frame),
        .empty      (stk_empty),
        .count      (nest_depth)
    );

    assign floor_lvl = stk_empty ? lvl_t'(0) : top_frame.entry;
    assign target    = cmd_target(cmd, cur_level, lvl_value);

    always_comb begin
        nxt_level = cur_level;
        nxt_lerr  = 1'b0;
        nxt_uflow = 1'b0;
        do_push   = 1'b0;
        do_pop    = 1'b0;
        if (accept) begin
            do_push   = 1'b1;
            nxt_level = pick_level;
        end else if (rti) begin
            if (stk_empty) begin
                nxt_uflow = 1'b1;
            end else begin
                do_pop    = 1'b1;
                nxt_level = top_frame.prev;
            end
        end else if (cmd != LCMD_NONE) begin
            if (target < floor_lvl) begin
                nxt_level = floor_lvl;
                nxt_lerr  = 1'b1;
            end else begin
                nxt_level = target;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_level     <= lvl_t'(NUM_LEVELS - 1);
            lower_err     <= 1'b0;
            pop_underflow <= 1'b0;
        end else begin
            cur_level     <= nxt_level;
            lower_err     <= nxt_lerr;
            pop_underflow <= nxt_uflow;
        end
    end

    assign irq_valid = pick_valid;
    assign irq_level = pick_level;
endmodule

// File: rtl/ipl_arbiter_chk.sv
module ipl_arbiter_chk
    import ipl_pkg::*;
#(
    parameter int DEPTH_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_ack,
    input logic               rti,
    input logic               irq_valid,
    input logic [LVL_W-1:0]   irq_level,
    input logic [LVL_W-1:0]   cur_level,
    input logic [DEPTH_W-1:0] nest_depth,
    input logic [LVL_W-1:0]   floor_lvl,
    input logic               pop_underflow
);
    assert_offer_strict_R4: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_level > cur_level));

    assert_accept_level_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_ack) |=>
            (cur_level == $past(irq_level)) && (nest_depth == $past(nest_depth) + DEPTH_W'(1)));

    assert_nest_bound_R5: assert property (@(posedge clk) disable iff (rst)
        nest_depth <= DEPTH_W'(NUM_LEVELS - 1));

    assert_pop_depth_R6: assert property (@(posedge clk) disable iff (rst)
        (rti && !(irq_valid && irq_ack) && nest_depth != '0) |=>
            (nest_depth == $past(nest_depth) - DEPTH_W'(1)));

    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (rst)
        (rti && !(irq_valid && irq_ack) && nest_depth == '0) |=>
            (pop_underflow && cur_level == $past(cur_level) && nest_depth == '0));

    assert_floor_held_R9: assert property (@(posedge clk) disable iff (rst)
        (nest_depth != '0) |-> (cur_level >= floor_lvl));
endmodule

bind ipl_arbiter ipl_arbiter_chk #(.DEPTH_W(DEPTH_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .irq_ack       (irq_ack),
    .rti           (rti),
    .irq_valid     (irq_valid),
    .irq_level     (irq_level),
    .cur_level     (cur_level),
    .nest_depth    (nest_depth),
    .floor_lvl     (floor_lvl),
    .pop_underflow (pop_underflow)
);

// File: tb/sim_ipl_arbiter.sv
module sim_ipl_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] hw_req = '0;
    logic [14:0] sw_post = '0;
    logic        irq_ack = 1'b0;
    logic        rti = 1'b0;
    logic [1:0]  lvl_cmd = '0;
    logic [4:0]  lvl_value = '0;
    logic        irq_valid;
    logic [4:0]  irq_level;
    logic [4:0]  cur_level;
    logic [5:0]  nest_depth;
    logic        lower_err;
    logic        pop_underflow;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_cur;
    int m_sw [1:15];
    int q_prev[$];
    int q_entry[$];
    int m_lerr;
    int m_uf;

    always #2 clk = ~clk;

    ipl_arbiter u0 (
        .clk(clk), .rst(rst), .hw_req(hw_req), .sw_post(sw_post),
        .irq_ack(irq_ack), .rti(rti), .lvl_cmd(lvl_cmd), .lvl_value(lvl_value),
        .irq_valid(irq_valid), .irq_level(irq_level), .cur_level(cur_level),
        .nest_depth(nest_depth), .lower_err(lower_err), .pop_underflow(pop_underflow)
    );

    function automatic int m_best();
        int b = 0;
        for (int l = 1; l < 16; l++) if (m_sw[l] != 0) b = l;
        for (int i = 0; i < 16; i++) if (hw_req[i]) b = 16 + i;
        return b;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cur = 31; m_lerr = 0; m_uf = 0;
            q_prev.delete(); q_entry.delete();
            for (int l = 1; l < 16; l++) m_sw[l] = 0;
        end else begin
            int best;
            int fl;
            int t;
            best = m_best();
            m_lerr = 0; m_uf = 0;
            if (irq_ack && best > m_cur) begin
                q_prev.push_back(m_cur);
                q_entry.push_back(best);
                m_cur = best;
                if (best < 16) m_sw[best] = 0;
            end else if (rti) begin
                if (q_prev.size() == 0) m_uf = 1;
                else begin
                    m_cur = q_prev.pop_back();
                    void'(q_entry.pop_back());
                end
            end else if (lvl_cmd != 0) begin
                fl = (q_entry.size() == 0) ? 0 : q_entry[q_entry.size()-1];
                if (lvl_cmd == 1) t = lvl_value;
                else if (lvl_cmd == 2) t = (lvl_value > m_cur) ? lvl_value : m_cur;
                else t = (lvl_value < m_cur) ? lvl_value : m_cur;
                if (t < fl) begin t = fl; m_lerr = 1; end
                m_cur = t;
            end
            for (int l = 1; l < 16; l++) if (sw_post[l-1]) m_sw[l] = 1;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int best;
        int v;
        best = m_best();
        v = (best > m_cur) ? 1 : 0;
        chk(cur_level, m_cur, "R5 model cur_level");
        chk(nest_depth, q_prev.size(), "R6 model nest_depth");
        chk(irq_valid, v, "R4 model irq_valid");
        if (v != 0) chk(irq_level, best, "R4 model irq_level");
        chk(lower_err, m_lerr, "R9 model lower_err");
        chk(pop_underflow, m_uf, "R7 model pop_underflow");
    endtask

    task automatic step(input logic [15:0] h, input logic [14:0] p, input logic a,
                        input logic r, input logic [1:0] c, input logic [4:0] v);
        @(negedge clk);
        hw_req = h; sw_post = p; irq_ack = a; rti = r; lvl_cmd = c; lvl_value = v;
        #1;
        compare_all();
    endtask

    task automatic idle();
        step('0, '0, 0, 0, 2'd0, 5'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        idle();
        chk(cur_level, 31, "R1 cur_level"); chk(nest_depth, 0, "R1 nest_depth");
        chk(irq_valid, 0, "R1 irq_valid"); chk(lower_err, 0, "R1 lower_err");
        chk(pop_underflow, 0, "R1 pop_underflow");
        // R4: level 31 not strictly above 31
        step(16'h8000, '0, 0, 0, 2'd0, 5'd0);
        chk(irq_valid, 0, "R4 equal level blocked");
        step('0, '0, 0, 0, 2'd1, 5'd0);            // set 0
        step(16'h0010, '0, 0, 0, 2'd0, 5'd0);      // line 4 -> level 20
        chk(cur_level, 0, "R8 set to 0");
        chk(lower_err, 0, "R9 no floor at depth 0");
        chk(irq_valid, 1, "R2 line offered"); chk(irq_level, 20, "R2 line level");
        idle();
        chk(irq_valid, 0, "R2 line not latched");
        step('0, 15'h0100, 0, 0, 2'd0, 5'd0);      // post level 9
        idle();
        chk(irq_valid, 1, "R3 post offered"); chk(irq_level, 9, "R3 post level");
        step(16'h0010, '0, 1, 0, 2'd0, 5'd0);
        chk(irq_level, 20, "R4 highest wins");
        idle();
        chk(cur_level, 20, "R5 accepted level"); chk(nest_depth, 1, "R5 depth");
        chk(irq_valid, 0, "R3 lower post blocked");
        step('0, '0, 0, 0, 2'd3, 5'd5);            // lower to 5
        idle();
        chk(cur_level, 20, "R9 clamped to entry"); chk(lower_err, 1, "R9 error pulse");
        step('0, '0, 0, 0, 2'd2, 5'd25);           // raise
        chk(lower_err, 0, "R9 pulse one cycle");
        step('0, '0, 0, 0, 2'd1, 5'd22);           // set 22
        chk(cur_level, 25, "R8 raise");
        step('0, '0, 0, 1, 2'd0, 5'd0);
        chk(cur_level, 22, "R8 set above floor"); chk(lower_err, 0, "R9 no error above floor");
        idle();
        chk(cur_level, 0, "R6 restored"); chk(nest_depth, 0, "R6 depth");
        chk(irq_level, 9, "R3 deferred request fires");
        step('0, 15'h0100, 1, 0, 2'd0, 5'd0);      // accept 9 and repost 9
        idle();
        chk(cur_level, 9, "R11 accepted"); chk(irq_valid, 0, "R11 equal blocked");
        step('0, '0, 0, 1, 2'd0, 5'd0);
        idle();
        chk(irq_valid, 1, "R11 still pending"); chk(irq_level, 9, "R11 level");
        step('0, '0, 1, 0, 2'd0, 5'd0);
        step('0, '0, 0, 1, 2'd0, 5'd0);
        chk(cur_level, 9, "R5 accepted again");
        idle();
        chk(irq_valid, 0, "R3 cleared by accept");
        step(16'h8000, '0, 1, 1, 2'd1, 5'd3);      // ack + rti + set together
        idle();
        chk(cur_level, 31, "R10 ack wins"); chk(nest_depth, 1, "R10 depth");
        step('0, '0, 0, 1, 2'd1, 5'd3);            // rti beats set
        step('0, '0, 0, 1, 2'd0, 5'd0);
        chk(cur_level, 0, "R10 rti wins over set"); chk(nest_depth, 0, "R10 popped");
        idle();
        chk(pop_underflow, 1, "R7 underflow"); chk(cur_level, 0, "R7 level kept");
        chk(nest_depth, 0, "R7 depth kept");
        idle();
        chk(pop_underflow, 0, "R7 pulse one cycle");
        // random phase against the model
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] h;
            logic [14:0] p;
            logic [1:0]  c;
            h = ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : '0;
            p = ($urandom_range(0, 4) == 0) ? 15'(1 << $urandom_range(0, 14)) : '0;
            c = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            step(h, p, 1'($urandom_range(0, 1)), ($urandom_range(0, 6) == 0),
                 c, 5'($urandom_range(0, 31)));
        end
        idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule